// File: doc/BRIEF.md
# Memory Barrier Issue Gate

This block sits between the in-order operation stream of a load/store unit and the memory pipeline. Every accepted entry is a load, a store, a barrier carrying a 5-bit type code, or an instruction-fetch request. Loads and stores are sent on to the memory pipeline with an epoch tag. The tag counts the barriers accepted before the operation, modulo the epoch ring depth. For each epoch the gate keeps two counts of operations still in flight. One falls when an operation passes the ordering point. The other falls when it becomes globally performed. The memory pipeline reports both events back with the operation's epoch tag.

A barrier closes the gate to younger loads and stores until its condition holds for every older epoch. Type 0x10 is the light ordering barrier. It releases once all older operations have passed the ordering point. Every other code, including 0x00 and any code the block does not implement, is the full completion barrier. It releases only once all older operations are globally performed. Barriers retire strictly in order, one per cycle at most. Fetch requests never wait at the gate.

Top module: `membar_gate`

## Requirements
- R1: A synchronous active-high reset clears all counts, epoch pointers and the error flag. After reset `gate_open` is 1, `proto_err` is 0, `disp_epoch` is 0, and a barrier would be accepted.
- R2: Kind codes are 0 for a load, 1 for a store, 2 for a barrier and 3 for a fetch. While the gate is open and `disp_ready` is high, a load or store is accepted and dispatched in the same cycle. Its `disp_epoch` equals the number of barriers accepted since reset, modulo DEPTH.
- R3: A barrier with type 0x00 holds every younger load and store (`in_ready` 0, `disp_valid` 0) until every older operation has a globally-performed acknowledgement. Ordering-point acknowledgements alone do not release it.
- R4: A barrier with type 0x10 releases younger loads and stores once every older operation has an ordering-point acknowledgement. It does not wait for globally-performed acknowledgements.
- R5: A barrier with any type code other than 0x10 (for example 0x03) behaves exactly like type 0x00.
- R6: A fetch (kind 3) is dispatched whenever `disp_ready` is high, even while a barrier holds the gate closed. It changes no count and no epoch.
- R7: A barrier accepted with nothing older outstanding makes `gate_open` 0 in the cycle after acceptance and 1 in the cycle after that.
- R8: Back-to-back barriers retire in acceptance order. An ordering barrier that follows a completion barrier does not open the gate before the completion barrier's condition is met. Once that happens, the two retire in consecutive cycles.
- R9: Up to DEPTH-1 epoch boundaries can be live at once. A further barrier sees `in_ready` 0 until an older epoch drains.
- R10: An acknowledgement whose epoch has a zero count of the matching kind sets `proto_err`. The flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input entry valid |
| in_ready | output | 1 | Input entry accepted this cycle when valid |
| in_kind | input | 2 | 0 load, 1 store, 2 barrier, 3 fetch |
| in_btype | input | 5 | Barrier type code |
| in_addr | input | AW | Access address |
| disp_valid | output | 1 | Dispatch to memory pipeline valid |
| disp_ready | input | 1 | Memory pipeline can take a request |
| disp_kind | output | 2 | Kind of the dispatched entry |
| disp_addr | output | AW | Address of the dispatched entry |
| disp_epoch | output | log2(DEPTH) | Epoch tag of the dispatched load/store |
| ord_ack | input | 1 | An operation passed the ordering point |
| ord_ack_epoch | input | log2(DEPTH) | Epoch tag of that operation |
| gp_ack | input | 1 | An operation became globally performed |
| gp_ack_epoch | input | log2(DEPTH) | Epoch tag of that operation |
| gate_open | output | 1 | No unretired barrier is pending |
| proto_err | output | 1 | Sticky acknowledgement protocol error |

## Verification
The bound checker watches several properties on every cycle. It checks that a load or store never leaves while the gate is closed and that a fetch always passes when the pipeline is ready. It also checks that an accepted barrier closes the gate on the next cycle and that the error flag never drops outside reset. Directed scenarios are needed for the rest. These cover which acknowledgement kind releases each barrier strength and the fallback of unknown codes to full completion. They also cover in-order retirement of stacked barriers, the exact retire latency of an idle barrier, epoch tag values and exhaustion of the epoch ring.

// File: rtl/membar_gate.sv
module membar_gate #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [1:0]               in_kind,
  input  logic [4:0]               in_btype,
  input  logic [AW-1:0]            in_addr,
  output logic                     disp_valid,
  input  logic                     disp_ready,
  output logic [1:0]               disp_kind,
  output logic [AW-1:0]            disp_addr,
  output logic [$clog2(DEPTH)-1:0] disp_epoch,
  input  logic                     ord_ack,
  input  logic [$clog2(DEPTH)-1:0] ord_ack_epoch,
  input  logic                     gp_ack,
  input  logic [$clog2(DEPTH)-1:0] gp_ack_epoch,
  output logic                     gate_open,
  output logic                     proto_err
);
  localparam int SW = $clog2(DEPTH);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [SW-1:0] FULL = SW'(DEPTH - 1);
  localparam logic [4:0] ORD_CODE = 5'h10;

  logic [SW-1:0]    head, rel, tail;
  logic [CW-1:0]    ocnt [DEPTH];
  logic [CW-1:0]    gcnt [DEPTH];
  logic [DEPTH-1:0] bord;
  logic             err_q;
  logic             blk_o, blk_g;

  wire is_bar = in_kind == 2'd2;
  wire is_if  = in_kind == 2'd3;
  wire is_mem = !in_kind[1];
  wire room   = (tail - head) != FULL;
  wire cnt_ok = (ocnt[tail] != CMAX) && (gcnt[tail] != CMAX);

  assign gate_open  = rel == tail;
  assign in_ready   = is_bar ? room : (is_if ? disp_ready : (gate_open && cnt_ok && disp_ready));
  assign disp_valid = in_valid && !is_bar && (is_if || (gate_open && cnt_ok));
  assign disp_kind  = in_kind;
  assign disp_addr  = in_addr;
  assign disp_epoch = tail;
  assign proto_err  = err_q;

  wire mem_fire = in_valid && is_mem && gate_open && cnt_ok && disp_ready;
  wire bar_fire = in_valid && is_bar && room;

  always_comb begin
    blk_o = 1'b0;
    blk_g = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((SW'(i) - head) <= (rel - head)) begin
        if (ocnt[i] != '0) blk_o = 1'b1;
        if (gcnt[i] != '0) blk_g = 1'b1;
      end
    end
  end

  wire retire = !gate_open && (bord[rel] ? !blk_o : !blk_g);
  wire pop    = (head != rel) && (ocnt[head] == '0) && (gcnt[head] == '0);
  wire bad    = (ord_ack && ocnt[ord_ack_epoch] == '0) || (gp_ack && gcnt[gp_ack_epoch] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      rel   <= '0;
      tail  <= '0;
      bord  <= '0;
      err_q <= 1'b0;
    end else begin
      if (bar_fire) begin
        bord[tail] <= in_btype == ORD_CODE;
        tail       <= tail + 1'b1;
      end
      if (retire) rel  <= rel + 1'b1;
      if (pop)    head <= head + 1'b1;
      if (bad)    err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        ocnt[i] <= '0;
        gcnt[i] <= '0;
      end else begin
        ocnt[i] <= ocnt[i]
                   + CW'(mem_fire && tail == SW'(i))
                   - CW'(ord_ack && ord_ack_epoch == SW'(i) && ocnt[i] != '0);
        gcnt[i] <= gcnt[i]
                   + CW'(mem_fire && tail == SW'(i))
                   - CW'(gp_ack && gp_ack_epoch == SW'(i) && gcnt[i] != '0);
      end
    end
  end
endmodule

module membar_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_kind,
  input logic       disp_valid,
  input logic       disp_ready,
  input logic       gate_open,
  input logic       proto_err
);
  a_r1_reset_open: assert property (@(posedge clk)
    rst |=> (gate_open && !proto_err));

  a_r3_closed_holds_mem: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_kind[1] && !gate_open) |-> (!disp_valid && !in_ready));

  a_r6_fetch_passes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd3 && disp_ready) |-> (in_ready && disp_valid));

  a_r7_barrier_closes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_kind == 2'd2) |=> !gate_open);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind membar_gate membar_gate_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .gate_open(gate_open), .proto_err(proto_err)
);

// File: tb/membar_gate_test.sv
module membar_gate_test;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'd0;
  logic [4:0]  in_btype = 5'd0;
  logic [31:0] in_addr = 32'd0;
  logic        disp_valid;
  logic        disp_ready = 1'b1;
  logic [1:0]  disp_kind;
  logic [31:0] disp_addr;
  logic [2:0]  disp_epoch;
  logic        ord_ack = 1'b0;
  logic [2:0]  ord_ack_epoch = 3'd0;
  logic        gp_ack = 1'b0;
  logic [2:0]  gp_ack_epoch = 3'd0;
  logic        gate_open;
  logic        proto_err;

  membar_gate #(.AW(32), .DEPTH(DEPTH), .CW(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_btype(in_btype), .in_addr(in_addr),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_kind(disp_kind),
    .disp_addr(disp_addr), .disp_epoch(disp_epoch),
    .ord_ack(ord_ack), .ord_ack_epoch(ord_ack_epoch),
    .gp_ack(gp_ack), .gp_ack_epoch(gp_ack_epoch),
    .gate_open(gate_open), .proto_err(proto_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] ep = 3'd0;
  int r, v, e;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] k, input logic [4:0] bt);
    in_valid = 1'b1; in_kind = k; in_btype = bt; in_addr = in_addr + 32'd4;
    #1;
    r = int'(in_ready); v = int'(disp_valid); e = int'(disp_epoch);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic bar(input logic [4:0] bt, input string req);
    send(2'd2, bt);
    chk(req, r, 1);
    ep = ep + 3'd1;
  endtask

  task automatic mem_op(input logic [1:0] k, input string req);
    send(k, 5'd0);
    chk(req, v, 1);
    chk(req, e, int'(ep));
  endtask

  task automatic ack_o(input logic [2:0] t);
    ord_ack = 1'b1; ord_ack_epoch = t; tick(); ord_ack = 1'b0;
  endtask

  task automatic ack_g(input logic [2:0] t);
    gp_ack = 1'b1; gp_ack_epoch = t; tick(); gp_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 gate_open", int'(gate_open), 1);
    chk("R1 proto_err", int'(proto_err), 0);
    chk("R1 disp_epoch", int'(disp_epoch), 0);
    in_valid = 1'b1; in_kind = 2'd2; #1;
    chk("R1 barrier ready", int'(in_ready), 1);
    in_valid = 1'b0; #1;
  endtask

  task automatic t_pass();
    mem_op(2'd0, "R2 load epoch 0");
    ack_o(ep); ack_g(ep);
  endtask

  task automatic t_idle_barrier();
    bar(5'h00, "R7 accept");
    chk("R7 closed after accept", int'(gate_open), 0);
    tick();
    chk("R7 open one cycle later", int'(gate_open), 1);
    mem_op(2'd1, "R2 store epoch 1");
    ack_o(ep); ack_g(ep);
  endtask

  task automatic t_completion();
    logic [2:0] old;
    old = ep;
    mem_op(2'd1, "R3 older store");
    bar(5'h00, "R3 accept");
    send(2'd0, 5'd0);
    chk("R3 younger held ready", r, 0);
    chk("R3 younger held valid", v, 0);
    ack_o(old); tick();
    chk("R3 ordering ack does not release", int'(gate_open), 0);
    ack_g(old); tick();
    chk("R3 released after gp ack", int'(gate_open), 1);
    mem_op(2'd0, "R3 younger load dispatched");
    ack_o(ep); ack_g(ep);
  endtask

  task automatic t_ordering();
    logic [2:0] old;
    old = ep;
    mem_op(2'd1, "R4 older store");
    bar(5'h10, "R4 accept");
    ack_o(old); tick();
    chk("R4 released on ordering ack", int'(gate_open), 1);
    mem_op(2'd0, "R4 younger load dispatched");
    ack_g(old);
    ack_o(ep); ack_g(ep);
  endtask

  task automatic t_unimpl();
    logic [2:0] old;
    old = ep;
    mem_op(2'd1, "R5 older store");
    bar(5'h03, "R5 accept");
    ack_o(old); tick(); tick();
    chk("R5 code 0x03 waits for gp", int'(gate_open), 0);
    ack_g(old); tick();
    chk("R5 code 0x03 released", int'(gate_open), 1);
  endtask

  task automatic t_fetch();
    logic [2:0] old;
    old = ep;
    mem_op(2'd1, "R6 older store");
    bar(5'h00, "R6 accept");
    send(2'd3, 5'd0);
    chk("R6 fetch ready", r, 1);
    chk("R6 fetch dispatched", v, 1);
    chk("R6 gate still closed", int'(gate_open), 0);
    ack_o(old); ack_g(old); tick();
    chk("R6 open after acks", int'(gate_open), 1);
  endtask

  task automatic t_b2b();
    logic [2:0] old;
    old = ep;
    mem_op(2'd1, "R8 older store");
    bar(5'h00, "R8 first");
    bar(5'h10, "R8 second");
    ack_o(old); tick(); tick();
    chk("R8 ordering barrier not early", int'(gate_open), 0);
    ack_g(old); tick();
    chk("R8 second still pending", int'(gate_open), 0);
    tick();
    chk("R8 both retired", int'(gate_open), 1);
  endtask

  task automatic t_full();
    logic [2:0] old;
    tick(); tick(); tick();
    old = ep;
    mem_op(2'd1, "R9 older store");
    for (int i = 0; i < DEPTH - 1; i++) bar(5'h00, "R9 barrier accepted");
    send(2'd2, 5'd0);
    chk("R9 ring full not ready", r, 0);
    ack_o(old); ack_g(old);
    repeat (12) tick();
    chk("R9 drained open", int'(gate_open), 1);
    mem_op(2'd1, "R9 epoch after wrap");
    ack_o(ep); ack_g(ep);
  endtask

  task automatic t_err();
    chk("R10 clean before", int'(proto_err), 0);
    ack_g(ep + 3'd3);
    chk("R10 flagged", int'(proto_err), 1);
    tick(); tick();
    chk("R10 sticky", int'(proto_err), 1);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset clears error", int'(proto_err), 0);
    chk("R1 reset opens gate", int'(gate_open), 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_pass();
    t_idle_barrier();
    t_completion();
    t_ordering();
    t_unimpl();
    t_fetch();
    t_b2b();
    t_full();
    t_err();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule